// File: doc/BRIEF.md
# Memory Bank Decoder and Bus Router

This block sits in front of a set of external-memory sequencers. Two internal buses can start an access: a system bus and a local bus. Each access arrives as a one-cycle strobe carrying an address and a source flag. The block holds a small table of bank descriptors. Each descriptor has a base address, an address mask, a valid flag and the number of the sequencer that serves the bank. A separate mode table records, for each sequencer, the bus that owns it.

On a strobe, every valid bank is compared with the address. The lowest-numbered hit is chosen. Its sequencer and that sequencer's owning bus form the grant. Routing between the buses is not symmetric. A system-bus access that lands on a local-bus bank is passed across to the local bus. A local-bus access that lands on a system-bus bank is refused. A miss and a refusal both raise a one-cycle no-hit pulse, so the requester can close the transfer.

Top module: `mem_bank_router`

## Requirements
- R1: After reset, `gnt_valid` and `nohit` are 0, every bank is invalid and every sequencer belongs to the system bus, so any access returns `nohit`.
- R2: A bank hits when its valid flag is 1 and `(req_addr & mask) == (base & mask)`.
- R3: When several banks hit, the grant names the lowest-numbered one.
- R4: The result of a strobe appears exactly one cycle after it as a one-cycle pulse of `gnt_valid` or `nohit`. Without a strobe, both stay 0.
- R5: `gnt_msel` equals the sequencer number stored in the winning bank's descriptor.
- R6: `gnt_bus` is the owning bus of the selected sequencer (0 = system, 1 = local). A system-bus access (`req_src` = 0) to a local-owned bank is granted with `gnt_bus` = 1.
- R7: A local-bus access (`req_src` = 1) whose winning bank's sequencer is owned by the system bus produces no grant and raises `nohit`.
- R8: An access that hits no bank raises `nohit` for one cycle.
- R9: A descriptor write in the same cycle as a strobe does not affect that strobe's decode. It takes effect from the next strobe.
- R10: `gnt_valid` and `nohit` are never 1 together. `gnt_bank`, `gnt_msel` and `gnt_bus` read 0 whenever `gnt_valid` is 0.
- R11: An invalid bank never hits, even when its base and mask match the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_we | input | 1 | Write one bank descriptor |
| bank_idx | input | BW | Bank being written |
| bank_base | input | AW | Base address to store |
| bank_mask | input | AW | Address mask to store |
| bank_valid | input | 1 | Valid flag to store |
| bank_msel | input | MW | Sequencer number to store |
| mode_we | input | 1 | Write one sequencer's bus owner |
| mode_idx | input | MW | Sequencer being written |
| mode_local | input | 1 | 1 = sequencer owned by local bus |
| req_valid | input | 1 | Access strobe |
| req_src | input | 1 | Requesting bus, 0 = system, 1 = local |
| req_addr | input | AW | Access address |
| gnt_valid | output | 1 | Grant pulse |
| gnt_bank | output | BW | Winning bank |
| gnt_msel | output | MW | Selected sequencer |
| gnt_bus | output | 1 | Target bus, 0 = system, 1 = local |
| nohit | output | 1 | Miss or refused access pulse |

## Verification
A descriptor write and an access strobe can land on the same clock edge. The decode must then use the table as it stood before that edge. The bench drives both in one cycle, on a bank that only hits after the write. It expects `nohit` for that strobe and a grant for an identical strobe one cycle later. A second overlap is a hit that is both granted by priority and refused by ownership. The bench judges this with a local-bus access whose lowest-numbered hit belongs to the system bus.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  localparam int unsigned MAX_AW = 64;

  typedef enum logic {BUS_SYS = 1'b0, BUS_LOC = 1'b1} bus_e;

  typedef struct packed {
    logic grant;
    logic refuse;
  } route_t;

  // Masked address compare on zero-extended operands.
  function automatic logic masked_eq(input logic [MAX_AW-1:0] a,
                                     input logic [MAX_AW-1:0] b,
                                     input logic [MAX_AW-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  // Asymmetric routing: a local source may only reach local-owned banks.
  function automatic route_t route_decide(input logic hit,
                                          input logic src_local,
                                          input logic bank_local);
    route_t r;
    r.grant  = hit && !(src_local && !bank_local);
    r.refuse = !r.grant;
    return r;
  endfunction

endpackage

// File: rtl/mbr_bank_regs.sv
module mbr_bank_regs #(
  parameter int unsigned AW    = 32,
  parameter int unsigned NBANK = 8,
  parameter int unsigned NMACH = 4,
  localparam int unsigned BW   = $clog2(NBANK),
  localparam int unsigned MW   = $clog2(NMACH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bank_we,
  input  logic [BW-1:0]               bank_idx,
  input  logic [AW-1:0]               bank_base,
  input  logic [AW-1:0]               bank_mask,
  input  logic                        bank_valid,
  input  logic [MW-1:0]               bank_msel,
  input  logic                        mode_we,
  input  logic [MW-1:0]               mode_idx,
  input  logic                        mode_local,
  output logic [NBANK-1:0][AW-1:0]    base_q,
  output logic [NBANK-1:0][AW-1:0]    mask_q,
  output logic [NBANK-1:0]            valid_q,
  output logic [NBANK-1:0][MW-1:0]    msel_q,
  output logic [NMACH-1:0]            local_q
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    wire sel_w = bank_we && (bank_idx == BW'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[b]  <= '0;
        mask_q[b]  <= '0;
        valid_q[b] <= 1'b0;
        msel_q[b]  <= '0;
      end else if (sel_w) begin
        base_q[b]  <= bank_base;
        mask_q[b]  <= bank_mask;
        valid_q[b] <= bank_valid;
        msel_q[b]  <= bank_msel;
      end
    end
  end

  for (genvar m = 0; m < NMACH; m++) begin : g_mode
    always_ff @(posedge clk) begin
      if (!rst_n)                                  local_q[m] <= 1'b0;
      else if (mode_we && (mode_idx == MW'(m)))    local_q[m] <= mode_local;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> (valid_q[$past(bank_idx)] == $past(bank_valid))); // R9

endmodule

// File: rtl/mbr_match_pri.sv
module mbr_match_pri
  import mbr_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NBANK = 8,
  localparam int unsigned BW   = $clog2(NBANK)
) (
  input  logic [AW-1:0]               addr,
  input  logic [NBANK-1:0][AW-1:0]    base_q,
  input  logic [NBANK-1:0][AW-1:0]    mask_q,
  input  logic [NBANK-1:0]            valid_q,
  output logic [NBANK-1:0]            hit_vec,
  output logic [NBANK-1:0]            win_vec,
  output logic                        hit_any,
  output logic [BW-1:0]               win_idx
);

  for (genvar b = 0; b < NBANK; b++) begin : g_cmp
    assign hit_vec[b] = valid_q[b] &&
                        masked_eq(MAX_AW'(addr), MAX_AW'(base_q[b]), MAX_AW'(mask_q[b]));
  end

  // Scan from the top so the lowest hit is written last.
  always_comb begin
    win_idx = '0;
    win_vec = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        win_idx = BW'(i);
        win_vec = NBANK'(1) << i;
      end
    end
  end

  assign hit_any = |hit_vec;

  always_comb begin
    AST_ONE_WINNER: assert ($onehot0(win_vec)); // R3
    AST_WIN_IS_HIT: assert ((win_vec & ~hit_vec) == '0); // R3
    AST_INVALID_QUIET: assert ((hit_vec & ~valid_q) == '0); // R11
  end

endmodule

// File: rtl/mem_bank_router.sv
module mem_bank_router
  import mbr_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NBANK = 8,
  parameter int unsigned NMACH = 4,
  localparam int unsigned BW   = $clog2(NBANK),
  localparam int unsigned MW   = $clog2(NMACH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_we,
  input  logic [BW-1:0] bank_idx,
  input  logic [AW-1:0] bank_base,
  input  logic [AW-1:0] bank_mask,
  input  logic          bank_valid,
  input  logic [MW-1:0] bank_msel,
  input  logic          mode_we,
  input  logic [MW-1:0] mode_idx,
  input  logic          mode_local,
  input  logic          req_valid,
  input  logic          req_src,
  input  logic [AW-1:0] req_addr,
  output logic          gnt_valid,
  output logic [BW-1:0] gnt_bank,
  output logic [MW-1:0] gnt_msel,
  output logic          gnt_bus,
  output logic          nohit
);

  logic [NBANK-1:0][AW-1:0] base_q, mask_q;
  logic [NBANK-1:0]         valid_q;
  logic [NBANK-1:0][MW-1:0] msel_q;
  logic [NMACH-1:0]         local_q;

  mbr_bank_regs #(.AW(AW), .NBANK(NBANK), .NMACH(NMACH)) u_regs (
    .clk, .rst_n, .bank_we, .bank_idx, .bank_base, .bank_mask,
    .bank_valid, .bank_msel, .mode_we, .mode_idx, .mode_local,
    .base_q, .mask_q, .valid_q, .msel_q, .local_q
  );

  logic [NBANK-1:0] hit_vec, win_vec;
  logic             hit_any;
  logic [BW-1:0]    win_idx;

  mbr_match_pri #(.AW(AW), .NBANK(NBANK)) u_match (
    .addr(req_addr), .base_q, .mask_q, .valid_q,
    .hit_vec, .win_vec, .hit_any, .win_idx
  );

  // Named internal events
  wire [MW-1:0] win_msel   = msel_q[win_idx];
  wire          win_local  = local_q[win_msel];
  route_t       rt;
  assign rt = route_decide(hit_any, req_src, win_local);
  wire          ev_grant   = req_valid && rt.grant;
  wire          ev_refuse  = req_valid && rt.refuse;
  wire          ev_cross   = ev_grant && !req_src && win_local;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      nohit     <= 1'b0;
      gnt_bank  <= '0;
      gnt_msel  <= '0;
      gnt_bus   <= BUS_SYS;
    end else begin
      gnt_valid <= ev_grant;
      nohit     <= ev_refuse;
      gnt_bank  <= ev_grant ? win_idx  : '0;
      gnt_msel  <= ev_grant ? win_msel : '0;
      gnt_bus   <= ev_grant ? win_local : BUS_SYS;
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_valid && nohit)); // R10
  AST_QUIET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> (gnt_bank == '0 && gnt_msel == '0 && !gnt_bus)); // R10
  AST_STROBE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (gnt_valid || nohit)); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(gnt_valid || nohit)); // R4
  AST_LOCAL_STAYS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src) |=> (!gnt_valid || gnt_bus)); // R7
  AST_CROSS_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cross |=> (gnt_valid && gnt_bus)); // R6

endmodule

// File: tb/mem_bank_router_test.sv
module mem_bank_router_test;

  localparam int AW = 32, NBANK = 8, NMACH = 4;
  localparam int BW = $clog2(NBANK), MW = $clog2(NMACH);
  localparam int VW = 1 + AW + 1 + 1 + BW + MW + 1;
  localparam int NV = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          bank_we = 1'b0, bank_valid = 1'b0, mode_we = 1'b0, mode_local = 1'b0;
  logic [BW-1:0] bank_idx = '0;
  logic [AW-1:0] bank_base = '0, bank_mask = '0, req_addr = '0;
  logic [MW-1:0] bank_msel = '0, mode_idx = '0;
  logic          req_valid = 1'b0, req_src = 1'b0;
  logic          gnt_valid, gnt_bus, nohit;
  logic [BW-1:0] gnt_bank;
  logic [MW-1:0] gnt_msel;

  mem_bank_router #(.AW(AW), .NBANK(NBANK), .NMACH(NMACH)) uut (
    .clk, .rst_n, .bank_we, .bank_idx, .bank_base, .bank_mask, .bank_valid,
    .bank_msel, .mode_we, .mode_idx, .mode_local, .req_valid, .req_src,
    .req_addr, .gnt_valid, .gnt_bank, .gnt_msel, .gnt_bus, .nohit
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // {src, addr, gnt, nohit, bank, msel, bus}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 32'h1234_5678, 1'b1, 1'b0, 3'd0, 2'd0, 1'b0},
    {1'b0, 32'h1100_0004, 1'b1, 1'b0, 3'd0, 2'd0, 1'b0},
    {1'b0, 32'h2000_0010, 1'b1, 1'b0, 3'd2, 2'd2, 1'b1},
    {1'b1, 32'h2000_0010, 1'b1, 1'b0, 3'd2, 2'd2, 1'b1},
    {1'b1, 32'h1000_0000, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0},
    {1'b0, 32'h3000_0000, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0},
    {1'b0, 32'h4000_FFFF, 1'b1, 1'b0, 3'd4, 2'd3, 1'b0},
    {1'b0, 32'h4001_0000, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0},
    {1'b1, 32'h4000_0000, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0},
    {1'b0, 32'h9000_0000, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0}
  };
  string vtag [NV] = '{"R2/R5", "R3", "R6", "R6", "R7", "R11", "R2/R5", "R8", "R7", "R8"};

  task automatic check(input string tag, input logic [7:0] exp);
    logic [7:0] act;
    act = {gnt_valid, nohit, gnt_bank, gnt_msel, gnt_bus};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got gv/nh/bank/msel/bus=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr_bank(input int b, input logic [AW-1:0] base, input logic [AW-1:0] mask,
                         input logic v, input int ms);
    @(negedge clk);
    bank_we = 1'b1; bank_idx = BW'(b); bank_base = base; bank_mask = mask;
    bank_valid = v; bank_msel = MW'(ms);
    @(negedge clk);
    bank_we = 1'b0;
  endtask

  task automatic wr_mode(input int m, input logic loc);
    @(negedge clk);
    mode_we = 1'b1; mode_idx = MW'(m); mode_local = loc;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  // Strobe at one negedge, capture at next posedge, sample at following negedge.
  task automatic access(input logic src, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_src = src; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 8'b0);
    rst_n = 1'b1;
    access(1'b0, 32'h1234_5678);
    check("R1 empty table gives nohit", {1'b0, 1'b1, 6'b0});
    @(negedge clk);
    check("R4 idle cycle quiet", 8'b0);

    wr_bank(0, 32'h1000_0000, 32'hF000_0000, 1'b1, 0);
    wr_bank(1, 32'h1100_0000, 32'hFF00_0000, 1'b1, 1);
    wr_bank(2, 32'h2000_0000, 32'hF000_0000, 1'b1, 2);
    wr_bank(3, 32'h3000_0000, 32'hF000_0000, 1'b0, 1);
    wr_bank(4, 32'h4000_0000, 32'hFFFF_0000, 1'b1, 3);
    wr_mode(1, 1'b1);
    wr_mode(2, 1'b1);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][VW-1], VEC[i][VW-2 -: AW]);
      check(vtag[i], VEC[i][7:0]);
      @(negedge clk);
      check("R4/R10 one-cycle pulse, quiet fields", 8'b0);
    end

    // Disable bank 0: bank 1 now wins for 0x11xx_xxxx, forwarded to local.
    wr_bank(0, 32'h1000_0000, 32'hF000_0000, 1'b0, 0);
    access(1'b0, 32'h1100_0004);
    check("R3/R6 next bank after disable", {1'b1, 1'b0, 3'd1, 2'd1, 1'b1});

    // Same-cycle descriptor write and strobe.
    @(negedge clk);
    bank_we = 1'b1; bank_idx = 3'd3; bank_base = 32'h3000_0000;
    bank_mask = 32'hF000_0000; bank_valid = 1'b1; bank_msel = 2'd0;
    req_valid = 1'b1; req_src = 1'b0; req_addr = 32'h3000_0000;
    @(negedge clk);
    bank_we = 1'b0; req_valid = 1'b0;
    check("R9 strobe sees old table", {1'b0, 1'b1, 6'b0});
    access(1'b0, 32'h3000_0000);
    check("R9 write visible next strobe", {1'b1, 1'b0, 3'd3, 2'd0, 1'b0});

    // Back-to-back strobes.
    @(negedge clk);
    req_valid = 1'b1; req_src = 1'b0; req_addr = 32'h2000_0000;
    @(negedge clk);
    check("R4 first of pair", {1'b1, 1'b0, 3'd2, 2'd2, 1'b1});
    req_addr = 32'h7000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 second of pair", {1'b0, 1'b1, 6'b0});

    // Reset clears table and bus owners.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 outputs after re-reset", 8'b0);
    rst_n = 1'b1;
    access(1'b0, 32'h2000_0000);
    check("R1 table cleared", {1'b0, 1'b1, 6'b0});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule